// File: doc/BRIEF.md
# Fetch-Address Predictor with Precomputed Branch Direction

This block sits beside an instruction-fetch unit and answers, one cycle after a fetch-block address is presented, with the address to fetch next. A direct-mapped table is indexed by the low bits of the fetch-block address and tagged with the high bits. Each entry holds a branch target, two histories of recent outcomes and one stored direction bit. On a hit the stored bit picks the cached target or the fall-through block (fetch address plus one). On a miss the next sequential block is fetched. Because the direction is worked out ahead of time and written back into the entry, the fetch path needs only one table read.

One table of 2-bit saturating counters is shared by all entries and indexed by history. Each counter is a four-state machine: `CTR_NT_STRONG` (0), `CTR_NT_WEAK` (1), `CTR_T_WEAK` (2) and `CTR_T_STRONG` (3). A taken outcome moves it one state up and a not-taken outcome one state down, and it saturates at both ends. States 2 and 3 read as taken. The path runs in two stages. The lookup stage registers the answer. The following stage shifts the predicted direction into the entry's speculative history and reads the counter table with that new history to refresh the stored bit. When the core resolves a branch, the committed (checkpoint) history advances and the counter it addressed is trained. On a mispredict, the speculative history is rebuilt from the checkpoint and the stored bit is recomputed.

Top module: `fetch_next_predictor`

## Requirements
- R1: After reset every entry is empty, every target and history is zero, and every counter is in state 3 (`CTR_T_STRONG`), so a branch allocated with any history is first predicted taken.
- R2: `nx_valid` is high exactly one cycle after a cycle with `fe_valid` high, and low one cycle after a cycle with `fe_valid` low.
- R3: The entry index is `fe_addr[IDX_W-1:0]` and the tag is the remaining upper bits. A hit needs a valid entry with an equal tag, so two addresses that share an index but differ in tag do not hit each other's entry.
- R4: On a fetch miss the block answers with `nx_addr = fe_addr + 1`, `nx_hit = 0` and `nx_taken = 0`.
- R5: On a fetch hit, `nx_taken` equals the stored direction bit, and `nx_addr` is the cached target when the bit is 1 and `fe_addr + 1` when it is 0.
- R6: In the cycle after a fetch hit, the entry's speculative history shifts left with the predicted direction entering bit 0. The stored bit becomes 1 if the counter at the new history is 2 or more, and 0 otherwise.
- R7: A fetch of an entry whose stored bit is being rewritten in the same cycle uses the newly computed bit, so the same block fetched in two consecutive cycles sees the update from the first.
- R8: A resolve that hits shifts the outcome into bit 0 of the checkpoint history. It moves the counter addressed by the old checkpoint history one state up on taken or one state down on not taken, saturating at 3 and 0.
- R9: A resolve hit with `rs_mispredict` high copies the new checkpoint history into the speculative history. It sets the stored bit from the counter at that history, including this cycle's counter change. Without `rs_mispredict`, the speculative history and stored bit are left alone.
- R10: A resolve that misses allocates the entry with the new tag and fills both histories with copies of the outcome bit. It sets the stored bit from the counter at that pattern and trains no counter.
- R11: The cached target is written with `rs_target` only by a resolve whose outcome is taken, whether it hits or misses. A not-taken resolve leaves the target unchanged.
- R12: When a resolve rewrites an entry's speculative history (a miss or a mispredict) in the same cycle as the speculative update of R6 for that same entry, the resolve's values are kept and the speculative update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | Fetch-block address is present |
| fe_addr | input | ADDR_W | Fetch-block address |
| nx_valid | output | 1 | Next-fetch answer is valid (one cycle after the request) |
| nx_addr | output | ADDR_W | Next fetch-block address |
| nx_hit | output | 1 | The request hit a table entry |
| nx_taken | output | 1 | The stored direction chose the cached target |
| rs_valid | input | 1 | A branch is being resolved |
| rs_addr | input | ADDR_W | Fetch-block address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_mispredict | input | 1 | The earlier prediction for this branch was wrong |
| rs_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench builds the block with 12-bit addresses, an 8-entry table and 3-bit histories. With these values two tags can alias on one index, and every counter pattern, including all-ones and all-zeros fills, is reached within a few resolves. Saturation at both ends is also reached in under ten cycles. A behavioural reference model is run against the block on every clock. It covers directed sequences for allocation, repair and same-cycle conflicts, followed by several thousand cycles of mixed traffic.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
package fp_pkg;

    typedef enum logic [1:0] {
        CTR_NT_STRONG = 2'd0,
        CTR_NT_WEAK   = 2'd1,
        CTR_T_WEAK    = 2'd2,
        CTR_T_STRONG  = 2'd3
    } ctr_e;

    // Counter state transition on a resolved outcome
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_NT_STRONG: nxt = taken ? CTR_NT_WEAK  : CTR_NT_STRONG;
            CTR_NT_WEAK:   nxt = taken ? CTR_T_WEAK   : CTR_NT_STRONG;
            CTR_T_WEAK:    nxt = taken ? CTR_T_STRONG : CTR_NT_WEAK;
            CTR_T_STRONG:  nxt = taken ? CTR_T_STRONG : CTR_T_WEAK;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return (c == CTR_T_WEAK) || (c == CTR_T_STRONG);
    endfunction

endpackage

// File: rtl/fp_pattern_table.sv
`timescale 1ns/1ps
module fp_pattern_table
    import fp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] rd_a_idx,
    output logic              rd_a_taken,
    input  logic [HIST_W-1:0] rd_b_idx,
    output logic              rd_b_taken
);

    localparam int DEPTH = 1 << HIST_W;

    ctr_e ctr_q [DEPTH];
    ctr_e upd_nxt;

    always_comb begin
        upd_nxt = ctr_step(ctr_q[upd_idx], upd_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_T_STRONG;
            end
        end else if (upd_en) begin
            ctr_q[upd_idx] <= upd_nxt;
        end
    end

    // Reads see the counter value being written in the same cycle
    always_comb begin
        rd_a_taken = ctr_says_taken((upd_en && rd_a_idx == upd_idx) ? upd_nxt : ctr_q[rd_a_idx]);
        rd_b_taken = ctr_says_taken((upd_en && rd_b_idx == upd_idx) ? upd_nxt : ctr_q[rd_b_idx]);
    end

    // R8
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && upd_taken && ctr_q[upd_idx] == CTR_T_STRONG
        |=> ctr_q[$past(upd_idx)] == CTR_T_STRONG);

    // R8
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_taken && ctr_q[upd_idx] == CTR_NT_STRONG
        |=> ctr_q[$past(upd_idx)] == CTR_NT_STRONG);

    // R8
    ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_taken && ctr_q[upd_idx] != CTR_NT_STRONG
        |=> $unsigned(ctr_q[$past(upd_idx)]) + 2'd1 == $unsigned($past(ctr_q[upd_idx])));

endmodule

// File: rtl/fp_branch_table.sv
`timescale 1ns/1ps
module fp_branch_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int HIST_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    // fetch lookup
    input  logic [IDX_W-1:0]        lk_idx,
    output logic                    lk_valid,
    output logic [ADDR_W-IDX_W-1:0] lk_tag,
    output logic [ADDR_W-1:0]       lk_target,
    output logic                    lk_pred,
    // speculative-history read for the second stage
    input  logic [IDX_W-1:0]        sp_idx,
    output logic [HIST_W-1:0]       sp_hist,
    // resolve side
    input  logic [IDX_W-1:0]        rs_idx,
    output logic                    rs_valid_e,
    output logic [ADDR_W-IDX_W-1:0] rs_tag_e,
    output logic [HIST_W-1:0]       rs_arch,
    input  logic                    rs_alloc,
    input  logic [ADDR_W-IDX_W-1:0] rs_tag_d,
    input  logic                    rs_arch_we,
    input  logic [HIST_W-1:0]       rs_arch_d,
    input  logic                    rs_tgt_we,
    input  logic [ADDR_W-1:0]       rs_tgt_d,
    // port A: resolve rewrite of speculative history and direction
    input  logic                    a_we,
    input  logic [HIST_W-1:0]       a_hist,
    input  logic                    a_pred,
    // port B: speculative update
    input  logic                    b_we,
    input  logic [IDX_W-1:0]        b_idx,
    input  logic [HIST_W-1:0]       b_hist,
    input  logic                    b_pred
);

    localparam int N     = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [N-1:0]      valid_q;
    logic [N-1:0]      pred_q;
    logic [TAG_W-1:0]  tag_q  [N];
    logic [ADDR_W-1:0] tgt_q  [N];
    logic [HIST_W-1:0] arch_q [N];
    logic [HIST_W-1:0] spec_q [N];

    logic b_eff;

    always_comb begin
        b_eff = b_we && !(a_we && b_idx == rs_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            pred_q  <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i]  <= '0;
                tgt_q[i]  <= '0;
                arch_q[i] <= '0;
                spec_q[i] <= '0;
            end
        end else begin
            if (rs_alloc) begin
                valid_q[rs_idx] <= 1'b1;
                tag_q[rs_idx]   <= rs_tag_d;
            end
            if (rs_arch_we) arch_q[rs_idx] <= rs_arch_d;
            if (rs_tgt_we)  tgt_q[rs_idx]  <= rs_tgt_d;
            if (b_eff) begin
                spec_q[b_idx] <= b_hist;
                pred_q[b_idx] <= b_pred;
            end
            if (a_we) begin
                spec_q[rs_idx] <= a_hist;
                pred_q[rs_idx] <= a_pred;
            end
        end
    end

    always_comb begin
        lk_valid   = valid_q[lk_idx];
        lk_tag     = tag_q[lk_idx];
        lk_target  = tgt_q[lk_idx];
        if (a_we && rs_idx == lk_idx)       lk_pred = a_pred;
        else if (b_eff && b_idx == lk_idx)  lk_pred = b_pred;
        else                                lk_pred = pred_q[lk_idx];
        sp_hist    = spec_q[sp_idx];
        rs_valid_e = valid_q[rs_idx];
        rs_tag_e   = tag_q[rs_idx];
        rs_arch    = arch_q[rs_idx];
    end

    // R10
    alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_alloc |=> valid_q[$past(rs_idx)] && tag_q[$past(rs_idx)] == $past(rs_tag_d));

    // R12
    spec_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_we && b_we && b_idx == rs_idx |=> spec_q[$past(rs_idx)] == $past(a_hist));

endmodule

// File: rtl/fetch_next_predictor.sv
`timescale 1ns/1ps
module fetch_next_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fe_valid,
    input  logic [ADDR_W-1:0] fe_addr,
    output logic              nx_valid,
    output logic [ADDR_W-1:0] nx_addr,
    output logic              nx_hit,
    output logic              nx_taken,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic              rs_mispredict,
    input  logic [ADDR_W-1:0] rs_target
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  fe_idx, rs_idx, s1_idx;
    logic [TAG_W-1:0]  fe_tag, rs_tag, lk_tag, rs_tag_e;
    logic              lk_valid, lk_pred, lk_hit;
    logic [ADDR_W-1:0] lk_target;
    logic [HIST_W-1:0] sp_hist, rs_arch, arch_new, fill, a_hist, b_hist;
    logic              rs_valid_e, rs_hit;
    logic              a_we, a_pred, b_pred;
    logic              s1_valid, s1_pred;

    always_comb begin
        fe_idx   = fe_addr[IDX_W-1:0];
        fe_tag   = fe_addr[ADDR_W-1:IDX_W];
        rs_idx   = rs_addr[IDX_W-1:0];
        rs_tag   = rs_addr[ADDR_W-1:IDX_W];
        lk_hit   = lk_valid && (lk_tag == fe_tag);
        rs_hit   = rs_valid_e && (rs_tag_e == rs_tag);
        arch_new = {rs_arch[HIST_W-2:0], rs_taken};
        fill     = {HIST_W{rs_taken}};
        a_hist   = rs_hit ? arch_new : fill;
        a_we     = rs_valid && (!rs_hit || rs_mispredict);
        b_hist   = {sp_hist[HIST_W-2:0], s1_pred};
    end

    fp_pattern_table #(.HIST_W(HIST_W)) u_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (rs_valid && rs_hit),
        .upd_idx    (rs_arch),
        .upd_taken  (rs_taken),
        .rd_a_idx   (a_hist),
        .rd_a_taken (a_pred),
        .rd_b_idx   (b_hist),
        .rd_b_taken (b_pred)
    );

    fp_branch_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_branch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (fe_idx),
        .lk_valid   (lk_valid),
        .lk_tag     (lk_tag),
        .lk_target  (lk_target),
        .lk_pred    (lk_pred),
        .sp_idx     (s1_idx),
        .sp_hist    (sp_hist),
        .rs_idx     (rs_idx),
        .rs_valid_e (rs_valid_e),
        .rs_tag_e   (rs_tag_e),
        .rs_arch    (rs_arch),
        .rs_alloc   (rs_valid && !rs_hit),
        .rs_tag_d   (rs_tag),
        .rs_arch_we (rs_valid),
        .rs_arch_d  (a_hist),
        .rs_tgt_we  (rs_valid && rs_taken),
        .rs_tgt_d   (rs_target),
        .a_we       (a_we),
        .a_hist     (a_hist),
        .a_pred     (a_pred),
        .b_we       (s1_valid),
        .b_idx      (s1_idx),
        .b_hist     (b_hist),
        .b_pred     (b_pred)
    );

    // Lookup stage registers: answer to the fetch unit and second-stage context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nx_valid <= 1'b0;
            nx_addr  <= '0;
            nx_hit   <= 1'b0;
            nx_taken <= 1'b0;
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_pred  <= 1'b0;
        end else begin
            nx_valid <= fe_valid;
            nx_hit   <= fe_valid && lk_hit;
            nx_taken <= fe_valid && lk_hit && lk_pred;
            nx_addr  <= (lk_hit && lk_pred) ? lk_target : fe_addr + ADDR_W'(1);
            s1_valid <= fe_valid && lk_hit;
            s1_idx   <= fe_idx;
            s1_pred  <= lk_pred;
        end
    end

    // R2
    nx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid |=> nx_valid);

    // R2
    nx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_valid |=> !nx_valid);

    // R4
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid && !lk_hit |=> nx_addr == $past(fe_addr) + ADDR_W'(1) && !nx_hit && !nx_taken);

    // R5
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nx_taken |-> nx_hit);

endmodule

// File: tb/test_fetch_next_predictor.sv
`timescale 1ns/1ps
module test_fetch_next_predictor;

    localparam int AW = 12;
    localparam int IW = 3;
    localparam int HW = 3;
    localparam int NE = 1 << IW;
    localparam int HP = 1 << HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fe_valid = 1'b0;
    logic [AW-1:0] fe_addr = '0;
    logic          nx_valid, nx_hit, nx_taken;
    logic [AW-1:0] nx_addr;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_addr = '0;
    logic          rs_taken = 1'b0;
    logic          rs_mispredict = 1'b0;
    logic [AW-1:0] rs_target = '0;

    always #10 clk = ~clk;

    fetch_next_predictor #(.ADDR_W(AW), .IDX_W(IW), .HIST_W(HW)) i_fetch_next_predictor (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_addr(fe_addr),
        .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_hit(nx_hit), .nx_taken(nx_taken),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
        .rs_mispredict(rs_mispredict), .rs_target(rs_target)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";

    // Reference model state
    logic          m_val  [NE];
    logic [AW-IW-1:0] m_tag [NE];
    logic [AW-1:0] m_tgt  [NE];
    logic [HW-1:0] m_arch [NE];
    logic [HW-1:0] m_spec [NE];
    logic          m_pred [NE];
    int            m_cnt  [HP];
    logic          ms_v, ms_pred;
    int            ms_idx;
    logic          e_v, e_hit, e_tk;
    logic [AW-1:0] e_addr;

    task automatic chk(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
            m_arch[i] = '0; m_spec[i] = '0; m_pred[i] = 1'b0;
        end
        for (int i = 0; i < HP; i++) m_cnt[i] = 3;
        ms_v = 1'b0; ms_idx = 0; ms_pred = 1'b0;
        e_v = 1'b0; e_hit = 1'b0; e_tk = 1'b0; e_addr = '0;
    endtask

    task automatic model_step();
        int            fi, ri;
        logic          old_hit, rhit, aw, p;
        logic [AW-1:0] old_tgt;
        logic [HW-1:0] nh, sh;
        fi      = int'(fe_addr[IW-1:0]);
        ri      = int'(rs_addr[IW-1:0]);
        old_hit = m_val[fi] && (m_tag[fi] == fe_addr[AW-1:IW]);
        old_tgt = m_tgt[fi];
        rhit    = m_val[ri] && (m_tag[ri] == rs_addr[AW-1:IW]);
        aw      = 1'b0;
        nh      = '0;
        if (rs_valid) begin
            if (rhit) begin
                if (rs_taken && m_cnt[m_arch[ri]] < 3) m_cnt[m_arch[ri]]++;
                if (!rs_taken && m_cnt[m_arch[ri]] > 0) m_cnt[m_arch[ri]]--;
                nh = (m_arch[ri] << 1) | HW'(rs_taken);
                m_arch[ri] = nh;
                aw = rs_mispredict;
            end else begin
                nh = rs_taken ? '1 : '0;
                m_val[ri] = 1'b1;
                m_tag[ri] = rs_addr[AW-1:IW];
                m_arch[ri] = nh;
                aw = 1'b1;
            end
            if (aw) begin
                m_spec[ri] = nh;
                m_pred[ri] = (m_cnt[nh] >= 2);
            end
            if (rs_taken) m_tgt[ri] = rs_target;
        end
        if (ms_v && !(aw && ri == ms_idx)) begin
            sh = (m_spec[ms_idx] << 1) | HW'(ms_pred);
            m_spec[ms_idx] = sh;
            m_pred[ms_idx] = (m_cnt[sh] >= 2);
        end
        p      = m_pred[fi];
        e_v    = fe_valid;
        e_hit  = fe_valid && old_hit;
        e_tk   = e_hit && p;
        e_addr = e_tk ? old_tgt : fe_addr + AW'(1);
        ms_v    = fe_valid && old_hit;
        ms_idx  = fi;
        ms_pred = p;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase, "nx_valid", AW'(nx_valid), AW'(e_v));
            if (e_v) begin
                chk(phase, "nx_hit",   AW'(nx_hit),   AW'(e_hit));
                chk(phase, "nx_taken", AW'(nx_taken), AW'(e_tk));
                chk(phase, "nx_addr",  nx_addr,       e_addr);
            end
        end
    end

    task automatic cyc(input logic fv, input logic [AW-1:0] fa,
                       input logic rv, input logic [AW-1:0] ra,
                       input logic rt, input logic rm, input logic [AW-1:0] rtg);
        fe_valid = fv; fe_addr = fa;
        rs_valid = rv; rs_addr = ra; rs_taken = rt; rs_mispredict = rm; rs_target = rtg;
        @(negedge clk);
    endtask

    task automatic fetch(input logic [AW-1:0] a);
        cyc(1'b1, a, 1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic idle();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic resolve(input logic [AW-1:0] a, input logic t, input logic m, input logic [AW-1:0] tg);
        cyc(1'b0, '0, 1'b1, a, t, m, tg);
    endtask

    localparam logic [AW-1:0] A  = 12'h009;  // tag 1, index 1
    localparam logic [AW-1:0] A2 = 12'h011;  // tag 2, index 1

    initial begin
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        idle();
        chk("R1", "nx_valid after reset", AW'(nx_valid), '0);

        phase = "R4";
        fetch(A);
        chk("R4", "miss hit flag", AW'(nx_hit), '0);
        chk("R4", "miss next address", nx_addr, 12'h00A);

        phase = "R10";
        resolve(A, 1'b0, 1'b0, 12'h777);
        fetch(A);
        chk("R10", "allocated entry hits", AW'(nx_hit), AW'(1));
        chk("R1", "reset counter predicts taken", AW'(nx_taken), AW'(1));
        chk("R11", "not-taken resolve kept target", nx_addr, 12'h000);

        phase = "R11";
        resolve(A, 1'b1, 1'b1, 12'h5A0);
        fetch(A);
        chk("R11", "taken resolve wrote target", nx_addr, 12'h5A0);

        phase = "R3";
        fetch(A2);
        chk("R3", "alias tag misses", AW'(nx_hit), '0);
        chk("R3", "alias next address", nx_addr, 12'h012);

        phase = "R6 R7";
        repeat (4) fetch(A);
        chk("R5", "repeated hit uses target", nx_addr, 12'h5A0);

        phase = "R8";
        repeat (6) resolve(A, 1'b0, 1'b1, '0);
        phase = "R9";
        fetch(A);
        chk("R9", "repaired direction not taken", AW'(nx_taken), '0);
        chk("R9", "fall-through address", nx_addr, 12'h00A);

        phase = "R12";
        cyc(1'b0, '0, 1'b1, A, 1'b1, 1'b1, 12'h321);
        fetch(A);
        chk("R12", "resolve wins over speculative update", nx_addr, 12'h321);

        phase = "R2";
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) fetch(A);
            else begin
                idle();
                chk("R2", "no answer after idle", AW'(nx_valid), '0);
            end
        end

        phase = "mixed R5 R6 R7 R8 R9 R10 R11 R12";
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] fa, ra;
            fa = {9'($urandom_range(1, 2)), 3'($urandom_range(0, NE - 1))};
            ra = {9'($urandom_range(1, 2)), 3'($urandom_range(0, NE - 1))};
            cyc($urandom_range(0, 9) < 7, fa,
                $urandom_range(0, 9) < 4, ra,
                1'($urandom_range(0, 1)), $urandom_range(0, 9) < 3,
                AW'($urandom));
        end
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule